// File: doc/BRIEF.md
# Single-Level Page Table Walker

The walker turns a virtual page number into a translation when a translation buffer misses. It adds the page number, scaled to a word index, to a page table base register. It reads the resulting 32-bit entry through a single request/response memory port. It then checks the entry and ends the walk with a one-cycle completion pulse. That pulse carries either the physical page number, the entry's permission bits and the joined physical address, or a fault code.

Software loads the base register through a write strobe. Each walk takes a private copy of the base when it is accepted, so switching the active table never disturbs a walk already in flight.

The caller states which kinds of access it wants (read, write, execute). A valid entry that lacks any of the wanted permissions gives an access-denied fault. An entry with its valid bit clear gives a not-present fault and no translation.

Top module: `pt_walker`

## Requirements
- R1: After reset `walk_ready` is 1, and `mem_req_valid`, `done` and `fault` are 0. The base register resets to 0.
- R2: The memory request address is the walk's base plus the virtual page number times 4, taken modulo 2^32.
- R3: The entry layout is: bit 31 valid, bit 30 read permission, bit 29 write permission, bit 28 execute permission, bits 19:0 physical page number. Bits 27:20 are ignored. A valid entry that grants every wanted access ends with `fault` = 0, `ppn` = bits 19:0 and `rights` = bits 30:28.
- R4: An entry with bit 31 clear ends with `fault` = 1, and `ppn`, `rights` and `paddr` are all zero, whatever the permission bits hold.
- R5: A valid entry that lacks a wanted permission ends with `fault` = 2, and `ppn`, `rights` and `paddr` are zero. In `walk_acc`, bit 2 asks for read, bit 1 for write and bit 0 for execute.
- R6: On success `paddr` is the physical page number in the upper bits with the 10-bit page offset given at acceptance below it, unchanged.
- R7: A base write takes effect only for walks accepted in a later cycle. A walk in progress, or one accepted in the same cycle as the write, uses the old base.
- R8: `walk_req` is accepted only while `walk_ready` is 1. A request made while busy is ignored and starts no memory access.
- R9: `done` is high for exactly one cycle per walk. `fault` is nonzero only while `done` is high.
- R10: Each walk issues exactly one memory request. `mem_req_valid` stays high with a stable address until `mem_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| base_we | input | 1 | Base register write strobe |
| base_wdata | input | 32 | New table base address |
| walk_req | input | 1 | Start a walk |
| walk_vpn | input | 22 | Virtual page number |
| walk_off | input | 10 | Page offset carried to the physical address |
| walk_acc | input | 3 | Wanted access: bit 2 read, bit 1 write, bit 0 execute |
| walk_ready | output | 1 | Walker idle, a request will be accepted |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Entry address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Page table entry |
| done | output | 1 | Walk finished, results valid this cycle |
| fault | output | 2 | 0 none, 1 not present, 2 access denied |
| ppn | output | 20 | Physical page number |
| rights | output | 3 | Entry permissions {read, write, execute} |
| paddr | output | 30 | Physical address {ppn, offset} |

## Verification
Walks use random page numbers, offsets, entries and wanted-access masks, with random delays on both the request handshake and the response. The random delays show whether the request address stays stable and whether a walk runs on a response that arrives late.

Directed entries set to not-present with every permission bit on separate a valid-bit check from a permission check. Entries that lack exactly one wanted permission show that each permission bit is compared on its own.

Further directed cases cover base writes in the accept cycle and during the request wait, requests made while a walk is busy, and a base near the top of the address space that makes the entry address wrap. These tell apart a snapshot of the base from a live read of it, and a one-request walk from one that restarts.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int ADDR_W  = 32,
  parameter int VPN_W   = 22,
  parameter int OFF_W   = 10,
  parameter int PPN_W   = 20,
  parameter int ENTRY_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     base_we,
  input  logic [ADDR_W-1:0]        base_wdata,
  input  logic                     walk_req,
  input  logic [VPN_W-1:0]         walk_vpn,
  input  logic [OFF_W-1:0]         walk_off,
  input  logic [2:0]               walk_acc,
  output logic                     walk_ready,
  output logic                     mem_req_valid,
  input  logic                     mem_req_ready,
  output logic [ADDR_W-1:0]        mem_req_addr,
  input  logic                     mem_rsp_valid,
  input  logic [ENTRY_W-1:0]       mem_rsp_data,
  output logic                     done,
  output logic [1:0]               fault,
  output logic [PPN_W-1:0]         ppn,
  output logic [2:0]               rights,
  output logic [PPN_W+OFF_W-1:0]   paddr
);
  localparam int PA_W  = PPN_W + OFF_W;
  localparam int V_BIT = ENTRY_W - 1;
  localparam int R_LO  = ENTRY_W - 4;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_CHECK, S_DONE} st_t;
  localparam logic [1:0] F_NONE = 2'd0, F_ABSENT = 2'd1, F_DENIED = 2'd2;

  st_t               st_q;
  logic [ADDR_W-1:0] base_q, wbase_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [OFF_W-1:0]  off_q;
  logic [2:0]        acc_q, ent_rwx_q, res_rwx_q;
  logic              ent_v_q;
  logic [PPN_W-1:0]  ent_ppn_q, res_ppn_q;
  logic [OFF_W-1:0]  res_off_q;
  logic [1:0]        res_fault_q;
  logic [1:0]        chk_fault;
  logic              unused_bits;

  assign unused_bits   = ^mem_rsp_data[R_LO-1:PPN_W];
  assign walk_ready    = (st_q == S_IDLE);
  assign mem_req_valid = (st_q == S_REQ);
  assign mem_req_addr  = wbase_q + ADDR_W'({vpn_q, 2'b00});
  assign done          = (st_q == S_DONE);
  assign fault         = res_fault_q;
  assign ppn           = res_ppn_q;
  assign rights        = res_rwx_q;
  assign paddr         = PA_W'({res_ppn_q, res_off_q});

  always_comb begin
    if (!ent_v_q)                       chk_fault = F_ABSENT;
    else if ((acc_q & ~ent_rwx_q) != 0) chk_fault = F_DENIED;
    else                                chk_fault = F_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      base_q      <= '0;
      wbase_q     <= '0;
      vpn_q       <= '0;
      off_q       <= '0;
      acc_q       <= '0;
      ent_v_q     <= 1'b0;
      ent_rwx_q   <= '0;
      ent_ppn_q   <= '0;
      res_fault_q <= F_NONE;
      res_ppn_q   <= '0;
      res_rwx_q   <= '0;
      res_off_q   <= '0;
    end else begin
      if (base_we) base_q <= base_wdata;
      case (st_q)
        S_IDLE: if (walk_req) begin
          wbase_q <= base_q;
          vpn_q   <= walk_vpn;
          off_q   <= walk_off;
          acc_q   <= walk_acc;
          st_q    <= S_REQ;
        end
        S_REQ: if (mem_req_ready) st_q <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          ent_v_q   <= mem_rsp_data[V_BIT];
          ent_rwx_q <= mem_rsp_data[V_BIT-1:R_LO];
          ent_ppn_q <= mem_rsp_data[PPN_W-1:0];
          st_q      <= S_CHECK;
        end
        S_CHECK: begin
          res_fault_q <= chk_fault;
          if (chk_fault == F_NONE) begin
            res_ppn_q <= ent_ppn_q;
            res_rwx_q <= ent_rwx_q;
            res_off_q <= off_q;
          end
          st_q <= S_DONE;
        end
        default: begin
          res_fault_q <= F_NONE;
          res_ppn_q   <= '0;
          res_rwx_q   <= '0;
          res_off_q   <= '0;
          st_q        <= S_IDLE;
        end
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R10
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> fault == F_NONE); // R9
  AST_FAULT_NO_XLATE: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault != F_NONE |-> ppn == '0 && rights == '0 && paddr == '0); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    walk_ready |-> !mem_req_valid && !done); // R8
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && $past(mem_req_valid) |-> $stable(mem_req_addr)); // R7
endmodule

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        base_we = 0;
  logic [31:0] base_wdata = 0;
  logic        walk_req = 0;
  logic [21:0] walk_vpn = 0;
  logic [9:0]  walk_off = 0;
  logic [2:0]  walk_acc = 0;
  logic        walk_ready, mem_req_valid, mem_req_ready = 0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = 0;
  logic        done;
  logic [1:0]  fault;
  logic [19:0] ppn;
  logic [2:0]  rights;
  logic [29:0] paddr;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] cur_base = 0;

  always #4 clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_off(walk_off), .walk_acc(walk_acc),
    .walk_ready(walk_ready), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault), .ppn(ppn), .rights(rights), .paddr(paddr));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] b, input logic [21:0] v);
    return b + {8'b0, v, 2'b00};
  endfunction

  function automatic logic [1:0] exp_fault(input logic [31:0] e, input logic [2:0] a);
    if (!e[31]) return 2'd1;
    if ((a & ~e[30:28]) != 0) return 2'd2;
    return 2'd0;
  endfunction

  // mode: 0 plain, 1 base write while request waits, 2 base write in accept cycle, 3 busy request
  task automatic walk(input logic [21:0] v, input logic [9:0] o, input logic [2:0] a,
                      input logic [31:0] e, input int rdly, input int sdly, input int mode,
                      input logic [31:0] nb);
    logic [31:0] wb;
    logic [1:0]  ef;
    wb = cur_base;
    ef = exp_fault(e, a);
    @(negedge clk);
    walk_req = 1; walk_vpn = v; walk_off = o; walk_acc = a;
    if (mode == 2) begin base_we = 1; base_wdata = nb; cur_base = nb; end
    @(negedge clk);
    walk_req = 0; base_we = 0;
    walk_vpn = ~v;
    for (int i = 0; i < rdly; i++) begin
      if (mode == 1 && i == 0) begin base_we = 1; base_wdata = nb; cur_base = nb; end
      chk(mem_req_valid, "R10 request held", mem_req_valid, 1);
      @(negedge clk);
      base_we = 0;
    end
    chk(mem_req_valid, "R10 request valid", mem_req_valid, 1);
    chk(mem_req_addr == exp_addr(wb, v), "R2/R7 entry address", mem_req_addr, exp_addr(wb, v));
    mem_req_ready = 1;
    @(negedge clk);
    mem_req_ready = 0;
    for (int i = 0; i < sdly; i++) begin
      if (mode == 3 && i == 0) begin walk_req = 1; walk_vpn = v + 22'd5; end
      chk(!mem_req_valid, "R10 single request", mem_req_valid, 0);
      @(negedge clk);
      walk_req = 0;
    end
    mem_rsp_valid = 1; mem_rsp_data = e;
    @(negedge clk);
    mem_rsp_valid = 0; mem_rsp_data = $urandom;
    chk(!done, "R9 no early done", done, 0);
    @(negedge clk);
    chk(done, "R9 done", done, 1);
    chk(fault == ef, ef == 1 ? "R4 fault" : (ef == 2 ? "R5 fault" : "R3 fault"), fault, ef);
    if (ef == 0) begin
      chk(ppn == e[19:0], "R3 ppn", ppn, e[19:0]);
      chk(rights == e[30:28], "R3 rights", rights, e[30:28]);
      chk(paddr == {e[19:0], o}, "R6 paddr", paddr, {e[19:0], o});
    end else begin
      chk(ppn == 0 && rights == 0 && paddr == 0, ef == 1 ? "R4 no xlate" : "R5 no xlate",
          {ppn, rights, paddr}, 0);
    end
    @(negedge clk);
    chk(!done && fault == 0, "R9 single pulse", {done, fault}, 0);
    chk(walk_ready, "R8 back to idle", walk_ready, 1);
    if (mode == 3) chk(!mem_req_valid, "R8 busy request ignored", mem_req_valid, 0);
  endtask

  initial begin
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=finish", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(walk_ready && !mem_req_valid && !done && fault == 0, "R1 reset state",
        {walk_ready, mem_req_valid, done, fault}, 5'b10000);
    rst_n = 1;
    @(negedge clk);
    chk(walk_ready && !mem_req_valid, "R1 idle after reset", {walk_ready, mem_req_valid}, 2'b10);
    walk(22'h12345, 10'h2a5, 3'b100, 32'hC00A_BCDE, 0, 0, 0, 0);
    walk(22'h00001, 10'h000, 3'b000, 32'h7000_1111, 1, 2, 0, 0);
    walk(22'h3FFFFF, 10'h3FF, 3'b111, 32'h70FF_FFFF, 2, 1, 0, 0);
    walk(22'h00010, 10'h011, 3'b010, 32'hA000_0055, 0, 0, 0, 0);
    walk(22'h00011, 10'h012, 3'b001, 32'hE000_0066, 0, 0, 0, 0);
    walk(22'h00012, 10'h013, 3'b001, 32'h9FF0_0077, 0, 0, 0, 0);
    walk(22'h00020, 10'h021, 3'b110, 32'hF0F0_0123, 3, 3, 1, 32'h0040_0000);
    walk(22'h00020, 10'h021, 3'b110, 32'hF0F0_0123, 0, 0, 0, 0);
    walk(22'h00030, 10'h031, 3'b100, 32'hC000_0abc, 0, 0, 2, 32'hFFFF_FFF0);
    walk(22'h00007, 10'h032, 3'b100, 32'hC000_0abd, 1, 0, 0, 0);
    walk(22'h00044, 10'h044, 3'b100, 32'hC000_0444, 0, 4, 3, 0);
    for (int n = 0; n < 60; n++) begin
      logic [31:0] e;
      int m;
      e = $urandom;
      if ($urandom_range(0, 3) == 0) e[31] = 0; else e[31] = 1;
      m = $urandom_range(0, 5);
      walk($urandom, $urandom, $urandom, e, $urandom_range(0, 3), $urandom_range(0, 3),
           (m > 3) ? 0 : m, $urandom);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule